// File: doc/BRIEF.md
# Clock Failure Monitor with Switchover

This block supervises two clock sources of a chip: a primary oscillator that normally drives the system clock and a slow backup oscillator. It receives single-cycle edge indications from both sources, already synchronized into the system clock domain. From these it decides whether either source has stopped. It does not multiplex clocks itself. It produces the effective clock-select code for a separate glitch-free multiplexer, two sticky failure flags and a failure interrupt pulse.

The two monitors behave differently. The primary monitor counts backup ticks between primary edges. When too many backup ticks pass with no primary edge, it flags a primary failure and forces the select code to the backup source. The processor then keeps running on the backup and can service the failure. The backup monitor counts system cycles between backup edges. When it times out, it raises only an alert and never alters the select code. From that point on, primary monitoring stays off until reset, because the backup clock it relies on can no longer be trusted.

Top module: `clk_fail_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, `prim_fail`, `bkup_fail` and `fail_irq` are 0 and `sel_eff` equals `sel_req`.
- R2: With primary monitoring active, `prim_fail` becomes 1 at the clock edge that samples the PRIM_LIMIT-th (default 10) `bkup_edge` with no `prim_edge` since the last `prim_edge`. A `prim_edge` restarts the count.
- R3: While `prim_fail` is 1, `sel_eff` is the backup code BKUP_CODE (default 2'b11), whatever the value of `sel_req`. While it is 0, `sel_eff` equals `sel_req`.
- R4: Primary monitoring is active only while `prim_det_en` is 1, `sel_req` is not BKUP_CODE and `bkup_fail` is 0. While it is inactive, the tick count is cleared and held at zero.
- R5: With backup monitoring active, `bkup_fail` becomes 1 at the edge that ends the BKUP_LIMIT-th (default 8000) consecutive system cycle with `bkup_edge` low. A cycle with `bkup_edge` high restarts the count.
- R6: A backup failure never changes `sel_eff`.
- R7: Backup monitoring is active only while `bkup_det_en` and `bkup_osc_en` are both 1 and `sel_req` is not BKUP_CODE. While it is inactive, the cycle count is cleared and held at zero.
- R8: Once `bkup_fail` is 1, `prim_fail` cannot become 1 until reset.
- R9: Both failure flags stay at 1 until reset, even when the detection enables are removed.
- R10: `fail_irq` is high for exactly the first cycle in which either failure flag reads 1, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prim_det_en | input | 1 | Enables primary-failure detection |
| bkup_det_en | input | 1 | Enables backup-failure detection |
| bkup_osc_en | input | 1 | Backup oscillator is powered |
| sel_req | input | 2 | Clock-select code requested by software |
| prim_edge | input | 1 | One-cycle pulse per synchronized primary clock edge |
| bkup_edge | input | 1 | One-cycle pulse per synchronized backup clock edge |
| sel_eff | output | 2 | Effective clock-select code for the clock mux |
| prim_fail | output | 1 | Sticky primary-failure flag |
| bkup_fail | output | 1 | Sticky backup-failure flag |
| fail_irq | output | 1 | One-cycle pulse when a failure flag first sets |

## Verification
The hardest situation to reach from the ports is a failed primary monitor that is blocked after a backup failure. Reaching it requires a full backup timeout first: thousands of quiet cycles with the right enables held steady. Only after that can the primary monitor be starved of primary edges while backup edges are supplied. The bench drives exactly BKUP_LIMIT-1 quiet cycles, then one restarting edge, then the full window to trigger the alert. It then feeds a stream of backup-only edges that would normally trip the primary monitor twice over, and confirms that neither the flag nor the select code moves. Held-off counting is proven by letting a disabled monitor run for most of a window and then showing that a full window is still needed once it is enabled.

// File: rtl/clkmon_pkg.sv
// Package: shared select-code type and default constants for the clock
// failure monitor. Assumes a 2-bit clock-select code.
package clkmon_pkg;
    typedef logic [1:0] clk_sel_t;

    // Select code of the low-rate backup oscillator
    localparam clk_sel_t SEL_BACKUP = 2'b11;

    // Backup ticks without a primary edge before primary is declared lost
    localparam int unsigned PRIM_TICKS_DEF = 10;

    // System cycles without a backup edge before backup is declared lost
    localparam int unsigned BKUP_CYCLES_DEF = 8000;
endpackage

// File: rtl/clkmon_gap_counter.sv
// Gap counter: counts qualifying events since the last restart event and
// reports a hit in the cycle whose event would complete LIMIT of them.
// Used twice: the primary monitor counts backup ticks, the backup monitor
// counts every system cycle. Assumes restart and count are one-cycle pulses
// in the clk domain; restart has priority over count.
module clkmon_gap_counter #(
    parameter int unsigned LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic restart,
    input  logic count,
    output logic hit
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] gap_q;

    // Track events since last restart; clear whenever monitoring is inactive
    always_ff @(posedge clk) begin
        if (!rst_n || !active || restart) begin
            gap_q <= '0;
        end else if (count && gap_q != LAST) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Flag the event that completes the window
    always_comb begin
        hit = active && !restart && count && (gap_q == LAST);
    end
endmodule

// File: rtl/clkmon_status.sv
// Status and select logic: turns monitor hits into sticky flags and a
// one-cycle interrupt, and overrides the select code after a primary
// failure. Assumes the hits come from clkmon_gap_counter instances.
module clkmon_status
    import clkmon_pkg::*;
#(
    parameter clk_sel_t BKUP_CODE = SEL_BACKUP
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     prim_hit,
    input  logic     bkup_hit,
    input  clk_sel_t sel_req,
    output clk_sel_t sel_eff,
    output logic     prim_fail,
    output logic     bkup_fail,
    output logic     fail_irq
);
    logic prim_set;
    logic bkup_set;

    // New failures: primary is locked out once the backup has failed
    always_comb begin
        bkup_set = bkup_hit && !bkup_fail;
        prim_set = prim_hit && !prim_fail && !bkup_fail && !bkup_hit;
    end

    // Sticky flags and the rising-edge interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prim_fail <= 1'b0;
            bkup_fail <= 1'b0;
            fail_irq  <= 1'b0;
        end else begin
            prim_fail <= prim_fail | prim_set;
            bkup_fail <= bkup_fail | bkup_set;
            fail_irq  <= prim_set | bkup_set;
        end
    end

    // Force the backup source once the primary has been lost
    always_comb begin
        sel_eff = prim_fail ? BKUP_CODE : sel_req;
    end
endmodule

// File: rtl/clk_fail_monitor.sv
// Clock failure monitor top. Watches a primary and a backup oscillator
// through synchronized edge pulses. It switches the select code to the
// backup on primary loss and raises an alert on backup loss. Assumes the
// edge inputs are one-cycle pulses already in the clk domain and that a
// separate glitch-free mux consumes sel_eff.
module clk_fail_monitor
    import clkmon_pkg::*;
#(
    parameter int unsigned PRIM_LIMIT = PRIM_TICKS_DEF,
    parameter int unsigned BKUP_LIMIT = BKUP_CYCLES_DEF,
    parameter logic [1:0]  BKUP_CODE  = SEL_BACKUP
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prim_det_en,
    input  logic       bkup_det_en,
    input  logic       bkup_osc_en,
    input  logic [1:0] sel_req,
    input  logic       prim_edge,
    input  logic       bkup_edge,
    output logic [1:0] sel_eff,
    output logic       prim_fail,
    output logic       bkup_fail,
    output logic       fail_irq
);
    logic on_backup;
    logic prim_active;
    logic bkup_active;
    logic prim_hit;
    logic bkup_hit;

    // Decide which monitors may run this cycle
    always_comb begin
        on_backup   = (sel_req == BKUP_CODE);
        prim_active = prim_det_en && !on_backup && !bkup_fail;
        bkup_active = bkup_det_en && bkup_osc_en && !on_backup;
    end

    // Primary monitor: backup ticks between primary edges
    clkmon_gap_counter #(.LIMIT(PRIM_LIMIT)) u_prim_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (prim_active),
        .restart (prim_edge),
        .count   (bkup_edge),
        .hit     (prim_hit)
    );

    // Backup monitor: system cycles between backup edges
    clkmon_gap_counter #(.LIMIT(BKUP_LIMIT)) u_bkup_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (bkup_active),
        .restart (bkup_edge),
        .count   (1'b1),
        .hit     (bkup_hit)
    );

    clkmon_status #(.BKUP_CODE(BKUP_CODE)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .prim_hit  (prim_hit),
        .bkup_hit  (bkup_hit),
        .sel_req   (sel_req),
        .sel_eff   (sel_eff),
        .prim_fail (prim_fail),
        .bkup_fail (bkup_fail),
        .fail_irq  (fail_irq)
    );
endmodule

// File: rtl/clkmon_chk.sv
// Checker for clk_fail_monitor: temporal properties over its ports.
// Attached to every instance of the top module through bind.
module clkmon_chk #(
    parameter logic [1:0] BKUP_CODE = 2'b11
) (
    input logic       clk,
    input logic       rst_n,
    input logic       prim_det_en,
    input logic       bkup_det_en,
    input logic       bkup_osc_en,
    input logic [1:0] sel_req,
    input logic       prim_edge,
    input logic       bkup_edge,
    input logic [1:0] sel_eff,
    input logic       prim_fail,
    input logic       bkup_fail,
    input logic       fail_irq
);
    // R2
    prim_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prim_fail) |-> $past(prim_det_en && bkup_edge && !prim_edge));

    // R3
    sel_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prim_fail |-> (sel_eff == BKUP_CODE));

    // R3
    sel_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prim_fail |-> (sel_eff == sel_req));

    // R7
    bkup_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bkup_fail) |-> $past(bkup_det_en && bkup_osc_en && (sel_req != BKUP_CODE) && !bkup_edge));

    // R8
    prim_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prim_fail) |-> !$past(bkup_fail));

    // R9
    prim_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prim_fail |=> prim_fail);

    // R9
    bkup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bkup_fail |=> bkup_fail);

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_irq |-> ($rose(prim_fail) || $rose(bkup_fail)));

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(prim_fail) || $rose(bkup_fail)) |-> fail_irq);
endmodule

bind clk_fail_monitor clkmon_chk #(.BKUP_CODE(BKUP_CODE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prim_det_en (prim_det_en),
    .bkup_det_en (bkup_det_en),
    .bkup_osc_en (bkup_osc_en),
    .sel_req     (sel_req),
    .prim_edge   (prim_edge),
    .bkup_edge   (bkup_edge),
    .sel_eff     (sel_eff),
    .prim_fail   (prim_fail),
    .bkup_fail   (bkup_fail),
    .fail_irq    (fail_irq)
);

// File: tb/sim_clk_fail_monitor.sv
`timescale 1ns/1ps
// Bench for clk_fail_monitor with default parameters (10 ticks, 8000 cycles,
// backup code 2'b11). Inputs change at falling edges; outputs are sampled at
// the following falling edge.
module sim_clk_fail_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prim_det_en = 1'b0;
    logic       bkup_det_en = 1'b0;
    logic       bkup_osc_en = 1'b0;
    logic [1:0] sel_req = 2'b00;
    logic       prim_edge = 1'b0;
    logic       bkup_edge = 1'b0;
    logic [1:0] sel_eff;
    logic       prim_fail;
    logic       bkup_fail;
    logic       fail_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clk_fail_monitor u0 (
        .clk(clk), .rst_n(rst_n), .prim_det_en(prim_det_en),
        .bkup_det_en(bkup_det_en), .bkup_osc_en(bkup_osc_en),
        .sel_req(sel_req), .prim_edge(prim_edge), .bkup_edge(bkup_edge),
        .sel_eff(sel_eff), .prim_fail(prim_fail), .bkup_fail(bkup_fail),
        .fail_irq(fail_irq)
    );

    // Vector: {prim_det_en, bkup_det_en, bkup_osc_en, sel_req[1:0], exp_sel[1:0]}
    localparam int NV = 6;
    localparam logic [6:0] VEC [NV] = '{
        7'b1_1_1_00_00, 7'b1_1_1_01_01, 7'b0_1_1_10_10,
        7'b1_0_0_11_11, 7'b0_0_1_01_01, 7'b1_1_0_10_10
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One system cycle with the given edge pulses
    task automatic cyc(input logic pe, input logic be);
        prim_edge = pe;
        bkup_edge = be;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        prim_edge = 1'b0;
        bkup_edge = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 prim_fail", prim_fail, 0);
        chk("R1 bkup_fail", bkup_fail, 0);
        chk("R1 fail_irq", fail_irq, 0);
        chk("R1 sel_eff", sel_eff, sel_req);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R3 pass-through table walk: both clocks alive, no failure
        for (int i = 0; i < NV; i++) begin
            {prim_det_en, bkup_det_en, bkup_osc_en, sel_req} = VEC[i][6:2];
            cyc(1'b1, 1'b1);
            chk("R3 pass-through sel_eff", sel_eff, VEC[i][1:0]);
            chk("R3 no flag", prim_fail | bkup_fail, 0);
        end

        // R2 primary detection with restart, R3 override, R9, R10
        sel_req = 2'b01; prim_det_en = 1; bkup_det_en = 1; bkup_osc_en = 1;
        do_reset();
        repeat (9) cyc(1'b0, 1'b1);
        chk("R2 nine ticks", prim_fail, 0);
        cyc(1'b1, 1'b1);
        repeat (9) cyc(1'b0, 1'b1);
        chk("R2 restart by primary edge", prim_fail, 0);
        cyc(1'b0, 1'b1);
        chk("R2 tenth tick", prim_fail, 1);
        chk("R10 irq on rise", fail_irq, 1);
        chk("R3 forced to backup", sel_eff, 3);
        cyc(1'b0, 1'b1);
        chk("R10 irq one cycle", fail_irq, 0);
        sel_req = 2'b00;
        cyc(1'b0, 1'b1);
        chk("R3 override ignores sel_req", sel_eff, 3);
        prim_det_en = 0;
        cyc(1'b1, 1'b1);
        chk("R9 prim sticky", prim_fail, 1);
        do_reset();

        // R4 hold-off while disabled or on backup source
        sel_req = 2'b01; prim_det_en = 0;
        repeat (20) cyc(1'b0, 1'b1);
        chk("R4 disabled", prim_fail, 0);
        prim_det_en = 1; sel_req = 2'b11;
        repeat (9) cyc(1'b0, 1'b1);
        chk("R4 on backup source", prim_fail, 0);
        sel_req = 2'b01;
        repeat (9) cyc(1'b0, 1'b1);
        chk("R4 count was cleared", prim_fail, 0);
        cyc(1'b0, 1'b1);
        chk("R4 full window after enable", prim_fail, 1);

        // R5 backup detection with restart, R6, R9, R10
        prim_det_en = 0; bkup_det_en = 1; bkup_osc_en = 1; sel_req = 2'b01;
        do_reset();
        repeat (7999) cyc(1'b0, 1'b0);
        chk("R5 7999 quiet cycles", bkup_fail, 0);
        cyc(1'b0, 1'b1);
        repeat (7999) cyc(1'b0, 1'b0);
        chk("R5 restart by backup edge", bkup_fail, 0);
        cyc(1'b0, 1'b0);
        chk("R5 8000th quiet cycle", bkup_fail, 1);
        chk("R10 irq on backup rise", fail_irq, 1);
        chk("R6 select unchanged", sel_eff, 1);
        cyc(1'b0, 1'b0);
        chk("R10 backup irq one cycle", fail_irq, 0);
        chk("R9 bkup sticky", bkup_fail, 1);

        // R8 primary locked out after backup failure
        prim_det_en = 1;
        repeat (25) cyc(1'b0, 1'b1);
        chk("R8 prim blocked", prim_fail, 0);
        chk("R8 select unchanged", sel_eff, 1);
        chk("R10 no further irq", fail_irq, 0);

        // R7 hold-off while oscillator off, detection off, or on backup
        prim_det_en = 0; bkup_osc_en = 0;
        do_reset();
        repeat (7000) cyc(1'b0, 1'b0);
        chk("R7 oscillator off", bkup_fail, 0);
        bkup_osc_en = 1;
        repeat (7999) cyc(1'b0, 1'b0);
        chk("R7 count was cleared", bkup_fail, 0);
        cyc(1'b0, 1'b0);
        chk("R7 full window after enable", bkup_fail, 1);
        bkup_det_en = 0;
        do_reset();
        repeat (9000) cyc(1'b0, 1'b0);
        chk("R7 detection off", bkup_fail, 0);
        bkup_det_en = 1; sel_req = 2'b11;
        repeat (9000) cyc(1'b0, 1'b0);
        chk("R7 on backup source", bkup_fail, 0);
        chk("R7 no irq", fail_irq, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule